// File: doc/BRIEF.md
# Debug Reset-Hold and Cache-Preserve Controller

This block sits between the chip's external reset pin, a small debug control register written from the JTAG side, and the processor core. It turns these into the core's internal reset. It also decides when the instruction cache must be cleared and when the core is told to begin fetching. A debugger can set a reset-hold bit while the pin is asserted. The core then stays in reset after the pin is released, which gives the debugger time to load code into the instruction cache.

When the debugger clears the hold bit, the core leaves reset and a fetch request for address 0 is issued. If the halt-mode bit is still set at that point, the cache is left alone, so the downloaded code survives. The debug register lives in the test-clock domain. It is cleared only by the test reset, so it survives assertions of the reset pin. The two debug bits reach the core-clock domain through a synchronizer chain. The JTAG state machine is abstracted as an update strobe with a data word.

Top module: `dbg_reset_hold`

## Requirements
- R1: While `rstPinN` is low, `coreRstN` is low; it falls without waiting for a `clk` edge.
- R2: Each assertion (falling edge) of `rstPinN` produces exactly one `icInvalidate` pulse, one `clk` cycle wide.
- R3: On a `tck` edge with `dbgUpdate` high, the debug register loads bit 0 of `dbgData` as halt-mode and bit 1 as reset-hold. All other bits are ignored. `dbgStatus` shows halt-mode in bit 0, reset-hold in bit 1 and zero in every other bit.
- R4: `trstN` low clears halt-mode and reset-hold at once. If this ends a hold, the release then behaves as in R9.
- R5: An assertion of `rstPinN` leaves halt-mode and reset-hold unchanged.
- R6: While reset-hold is set, `coreRstN` stays low, even after `rstPinN` is released. Setting reset-hold while the core runs puts it back into reset without an `icInvalidate` pulse.
- R7: `coreRstN` rises only on a `clk` edge. `fetchStart` pulses for exactly the first cycle that `coreRstN` is high, and `fetchAddr` is 0.
- R8: A release caused by reset-hold clearing while halt-mode is set produces no `icInvalidate` pulse.
- R9: A release caused by reset-hold clearing while halt-mode is clear produces one `icInvalidate` pulse, in the same cycle as `fetchStart`.
- R10: A release caused by `rstPinN` going high, with reset-hold clear, produces no second `icInvalidate` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstPinN | input | 1 | External reset pin, active low, asynchronous |
| tck | input | 1 | Test clock for the debug register |
| trstN | input | 1 | Test reset, active low, asynchronous |
| dbgUpdate | input | 1 | Update strobe of a debug-register scan, `tck` domain |
| dbgData | input | DBG_W | Scanned data word for the debug register |
| dbgStatus | output | DBG_W | Debug register contents for capture |
| coreRstN | output | 1 | Internal core reset, active low |
| icInvalidate | output | 1 | One-cycle instruction-cache clear request |
| fetchStart | output | 1 | One-cycle request to start fetching |
| fetchAddr | output | ADDR_W | Fetch address for `fetchStart`, always 0 |

## Verification
The assertions assume that the debug bits, once written, stay stable for at least four `clk` cycles. This lets the window check on a held reset see a settled synchronizer. They also assume that `rstPinN` and `trstN` change asynchronously but do not glitch. The bench writes the register only at falling `tck` edges and allows ten or more `clk` cycles between scans and pin changes. It also lets the flops that have no reset settle for a warm-up period before any check is made.

// File: rtl/dbgrst_pkg.sv
`timescale 1ns/1ps
package dbgrst_pkg;
  localparam int HALT_BIT = 0;
  localparam int HOLD_BIT = 1;
  localparam int CTL_BITS = 2;

  typedef struct packed {
    logic rstReq;    // internal reset requested this cycle
    logic invalStb;  // clear the instruction cache
    logic wakeStb;   // reset just released, begin fetching
  } ctlStrobes_t;
endpackage

// File: rtl/dbgrst_regs.sv
`timescale 1ns/1ps
module dbgrst_regs
  import dbgrst_pkg::*;
#(
  parameter int DBG_W = 8
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             dbgUpdate,
  input  logic [DBG_W-1:0] dbgData,
  output logic [CTL_BITS-1:0] dbgBits,
  output logic [DBG_W-1:0] dbgStatus
);
  logic haltQ;
  logic holdQ;
  logic unusedUpper;

  // Only the two control fields are stored; the rest of the word is dropped.
  assign unusedUpper = ^dbgData;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      haltQ <= 1'b0;
      holdQ <= 1'b0;
    end else if (dbgUpdate) begin
      haltQ <= dbgData[HALT_BIT];
      holdQ <= dbgData[HOLD_BIT];
    end
  end

  assign dbgBits[HALT_BIT] = haltQ;
  assign dbgBits[HOLD_BIT] = holdQ;

  for (genvar i = 0; i < DBG_W; i++) begin : g_status
    if (i == HALT_BIT) begin : g_halt
      assign dbgStatus[i] = haltQ;
    end else if (i == HOLD_BIT) begin : g_hold
      assign dbgStatus[i] = holdQ;
    end else begin : g_zero
      assign dbgStatus[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dbgrst_control.sv
`timescale 1ns/1ps
module dbgrst_control
  import dbgrst_pkg::*;
(
  input  logic        clk,
  input  logic        pinActive,
  input  logic        holdS,
  input  logic        haltS,
  output ctlStrobes_t ctl
);
  logic pinActiveD;
  logic rstReqD;
  logic rstReq;
  logic pinRise;
  logic wake;
  logic holdWake;

  assign rstReq   = pinActive | holdS;
  assign pinRise  = pinActive & ~pinActiveD;
  assign wake     = rstReqD & ~rstReq;
  // The pin was already gone last cycle, so the hold bit ended the reset.
  assign holdWake = wake & ~pinActiveD;

  // History flops with no reset: they follow their inputs every cycle and
  // settle while the clock runs under reset.
  always_ff @(posedge clk) begin
    pinActiveD <= pinActive;
    rstReqD    <= rstReq;
  end

  always_comb begin
    ctl.rstReq   = rstReq;
    ctl.invalStb = pinRise | (holdWake & ~haltS);
    ctl.wakeStb  = wake;
  end
endmodule

// File: rtl/dbgrst_datapath.sv
`timescale 1ns/1ps
module dbgrst_datapath
  import dbgrst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic                clk,
  input  logic                rstPinN,
  input  logic                trstN,
  input  logic [CTL_BITS-1:0] dbgBits,
  input  ctlStrobes_t         ctl,
  output logic                pinActive,
  output logic                holdS,
  output logic                haltS,
  output logic                coreRstN,
  output logic                icInvalidate,
  output logic                fetchStart,
  output logic [ADDR_W-1:0]   fetchAddr
);
  logic [SYNC_STAGES-1:0] pinChain;
  logic [SYNC_STAGES-1:0] bitChain [CTL_BITS];
  logic coreRstQ;
  logic invalQ;
  logic fetchQ;

  // Pin reset: asserted asynchronously, released through the chain.
  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) pinChain <= '1;
    else          pinChain <= {pinChain[SYNC_STAGES-2:0], 1'b0};
  end
  assign pinActive = pinChain[SYNC_STAGES-1];

  // Debug bits cross from the test clock; only the test reset clears them.
  for (genvar b = 0; b < CTL_BITS; b++) begin : g_sync
    always_ff @(posedge clk or negedge trstN) begin
      if (!trstN) bitChain[b] <= '0;
      else        bitChain[b] <= {bitChain[b][SYNC_STAGES-2:0], dbgBits[b]};
    end
  end
  assign holdS = bitChain[HOLD_BIT][SYNC_STAGES-1];
  assign haltS = bitChain[HALT_BIT][SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) coreRstQ <= 1'b0;
    else          coreRstQ <= ~ctl.rstReq;
  end

  always_ff @(posedge clk) begin
    invalQ <= ctl.invalStb;
    fetchQ <= ctl.wakeStb;
  end

  assign coreRstN     = coreRstQ;
  assign icInvalidate = invalQ;
  assign fetchStart   = fetchQ;
  assign fetchAddr    = RESET_VEC;
endmodule

// File: rtl/dbg_reset_hold.sv
`timescale 1ns/1ps
module dbg_reset_hold
  import dbgrst_pkg::*;
#(
  parameter int DBG_W       = 8,
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              tck,
  input  logic              trstN,
  input  logic              dbgUpdate,
  input  logic [DBG_W-1:0]  dbgData,
  output logic [DBG_W-1:0]  dbgStatus,
  output logic              coreRstN,
  output logic              icInvalidate,
  output logic              fetchStart,
  output logic [ADDR_W-1:0] fetchAddr
);
  logic [CTL_BITS-1:0] dbgBits;
  ctlStrobes_t         ctl;
  logic                pinActive;
  logic                holdS;
  logic                haltS;

  dbgrst_regs #(.DBG_W(DBG_W)) regsInst (
    .tck(tck), .trstN(trstN), .dbgUpdate(dbgUpdate), .dbgData(dbgData),
    .dbgBits(dbgBits), .dbgStatus(dbgStatus)
  );

  dbgrst_control ctrlInst (
    .clk(clk), .pinActive(pinActive), .holdS(holdS), .haltS(haltS), .ctl(ctl)
  );

  dbgrst_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .RESET_VEC('0)
  ) dpInst (
    .clk(clk), .rstPinN(rstPinN), .trstN(trstN), .dbgBits(dbgBits), .ctl(ctl),
    .pinActive(pinActive), .holdS(holdS), .haltS(haltS),
    .coreRstN(coreRstN), .icInvalidate(icInvalidate),
    .fetchStart(fetchStart), .fetchAddr(fetchAddr)
  );
endmodule

// File: rtl/dbg_reset_hold_chk.sv
`timescale 1ns/1ps
module dbg_reset_hold_chk #(
  parameter int DBG_W = 8
) (
  input logic             clk,
  input logic             rstPinN,
  input logic             trstN,
  input logic [DBG_W-1:0] dbgStatus,
  input logic             coreRstN,
  input logic             icInvalidate,
  input logic             fetchStart
);
  // Flops without reset settle during the first edges; checks wait for them.
  logic [3:0] warmCnt = 4'd0;
  logic       warm;
  always @(posedge clk) if (warmCnt != 4'hF) warmCnt <= warmCnt + 4'd1;
  assign warm = (warmCnt >= 4'd8);

  // R1
  pin_holds_core_chk: assert property (@(posedge clk) disable iff (!warm)
    !rstPinN |-> !coreRstN);

  // R2
  inval_single_chk: assert property (@(posedge clk) disable iff (!warm)
    icInvalidate |=> !icInvalidate);

  // R4
  trst_clears_chk: assert property (@(posedge clk) disable iff (!warm)
    !trstN |-> (dbgStatus[1:0] == 2'b00));

  // R6
  hold_keeps_core_chk: assert property (@(posedge clk) disable iff (!warm)
    (dbgStatus[1] && $past(dbgStatus[1]) && $past(dbgStatus[1], 2) &&
     $past(dbgStatus[1], 3)) |-> !coreRstN);

  // R7
  fetch_on_wake_chk: assert property (@(posedge clk) disable iff (!warm)
    $rose(coreRstN) |-> fetchStart);

  // R7
  fetch_single_chk: assert property (@(posedge clk) disable iff (!warm)
    fetchStart |=> !fetchStart);
endmodule

bind dbg_reset_hold dbg_reset_hold_chk #(.DBG_W(DBG_W)) chkInst (
  .clk(clk), .rstPinN(rstPinN), .trstN(trstN), .dbgStatus(dbgStatus),
  .coreRstN(coreRstN), .icInvalidate(icInvalidate), .fetchStart(fetchStart)
);

// File: tb/dbg_reset_hold_test.sv
`timescale 1ns/1ps
module dbg_reset_hold_test;
  localparam int DBG_W  = 8;
  localparam int ADDR_W = 32;

  typedef enum logic {EV_INVAL, EV_FETCH} evKind_t;

  logic clk = 1'b0;
  logic tck = 1'b0;
  logic rstPinN, trstN, dbgUpdate;
  logic [DBG_W-1:0]  dbgData;
  logic [DBG_W-1:0]  dbgStatus;
  logic              coreRstN, icInvalidate, fetchStart;
  logic [ADDR_W-1:0] fetchAddr;

  int checks = 0;
  int fails  = 0;
  bit monOn  = 1'b0;
  bit done   = 1'b0;
  evKind_t expKind[$];
  string   expReq[$];

  always #4  clk = ~clk;
  always #10 tck = ~tck;

  dbg_reset_hold #(.DBG_W(DBG_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstPinN(rstPinN), .tck(tck), .trstN(trstN),
    .dbgUpdate(dbgUpdate), .dbgData(dbgData), .dbgStatus(dbgStatus),
    .coreRstN(coreRstN), .icInvalidate(icInvalidate),
    .fetchStart(fetchStart), .fetchAddr(fetchAddr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expectEv(input evKind_t k, input string req);
    expKind.push_back(k);
    expReq.push_back(req);
  endtask

  task automatic popEv(input evKind_t seen);
    checks++;
    if (expKind.size() == 0) begin
      fails++;
      $display("FAIL unexpected pulse: actual %s expected none",
               seen == EV_INVAL ? "invalidate" : "fetch");
    end else begin
      evKind_t k = expKind.pop_front();
      string   r = expReq.pop_front();
      if (k != seen) begin
        fails++;
        $display("FAIL %s: actual %s expected %s", r,
                 seen == EV_INVAL ? "invalidate" : "fetch",
                 k == EV_INVAL ? "invalidate" : "fetch");
      end
    end
  endtask

  // Monitor: compares each produced pulse with the next expected item.
  always @(negedge clk) begin
    if (monOn) begin
      if (icInvalidate) popEv(EV_INVAL);
      if (fetchStart)   popEv(EV_FETCH);
    end
  end

  task automatic drained(input string req);
    checks++;
    if (expKind.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %0d pending pulses expected 0", req, expKind.size());
      expKind.delete();
      expReq.delete();
    end
  endtask

  task automatic scanWrite(input logic [DBG_W-1:0] v);
    @(negedge tck);
    dbgData   = v;
    dbgUpdate = 1'b1;
    @(negedge tck);
    dbgUpdate = 1'b0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstPinN = 1'b1; trstN = 1'b0; dbgUpdate = 1'b0; dbgData = '0;
    waitClk(12);
    monOn = 1'b1;
    // Reset state: test reset clears the register, nothing holds the core.
    check("R4 reset status", dbgStatus, 0);
    check("R7 idle core", coreRstN, 1);

    // Cold reset with the test reset still asserted.
    expectEv(EV_INVAL, "R2 cold invalidate");
    #3 rstPinN = 1'b0;
    #1 check("R1 async core reset", coreRstN, 0);
    waitClk(6);
    drained("R2 one pulse");

    // Debugger sets halt and hold while the pin is low; upper bits ignored.
    trstN = 1'b1;
    scanWrite(8'hFF);
    check("R3 status fields", dbgStatus, 8'h03);
    rstPinN = 1'b1;
    waitClk(20);
    check("R6 held after pin", coreRstN, 0);
    drained("R6 no fetch while held");

    // Clear hold, keep halt: fetch without invalidate.
    expectEv(EV_FETCH, "R8 fetch on hold clear");
    scanWrite(8'h01);
    waitClk(10);
    drained("R8 no invalidate");
    check("R7 core released", coreRstN, 1);
    check("R7 fetch address", fetchAddr, 0);
    check("R3 halt only", dbgStatus, 8'h01);

    // Pin reset with hold clear: one invalidate, fetch on pin release.
    expectEv(EV_INVAL, "R2 pin invalidate");
    rstPinN = 1'b0;
    waitClk(6);
    check("R5 register kept", dbgStatus, 8'h01);
    drained("R2 single pulse");
    expectEv(EV_FETCH, "R10 fetch on pin release");
    rstPinN = 1'b1;
    waitClk(10);
    drained("R10 no second invalidate");
    check("R10 core released", coreRstN, 1);

    // Hold set while running, halt clear.
    scanWrite(8'h02);
    waitClk(10);
    check("R6 hold asserts reset", coreRstN, 0);
    drained("R6 no invalidate on hold");
    expectEv(EV_INVAL, "R9 invalidate on release");
    expectEv(EV_FETCH, "R9 fetch on release");
    scanWrite(8'h00);
    waitClk(10);
    drained("R9 both pulses");
    check("R9 core released", coreRstN, 1);

    // Test reset ends a hold even with halt set.
    scanWrite(8'h03);
    waitClk(10);
    check("R6 hold with halt", coreRstN, 0);
    expectEv(EV_INVAL, "R4 invalidate after test reset");
    expectEv(EV_FETCH, "R4 fetch after test reset");
    trstN = 1'b0;
    #1 check("R4 async clear", dbgStatus, 0);
    waitClk(10);
    drained("R4 release pulses");
    check("R4 core released", coreRstN, 1);
    trstN = 1'b1;
    waitClk(4);

    finishRun();
  end
endmodule